// File: doc/BRIEF.md
# Buffer Watermark Interrupt Generator

This block turns a buffer fill level into an interrupt for a host. Each cycle it compares the current entry count with a threshold taken from a 16-bit configuration word. It then drives one interrupt pin and one status flag from that comparison. The pin has two modes. In level mode it is a static active-high signal. In toggle mode it is a square wave of 50% duty cycle, and a host that starts a drain on each rising edge can use it as a train of triggers. With the default divider the wave runs at about 10 kHz from a 100 MHz clock.

Once a toggle run has started, it keeps going until the buffer is completely empty, even if the count falls below the threshold on the way down. It stops only when the count reaches zero. A later sample that brings the count back up to the threshold starts a new run. A global hold input forces the pin low, for example while device commands are being executed.

The count, configuration and hold are plain control inputs that are sampled every clock. No data stream crosses this block, so there is no valid/ready handshake and no back-pressure. The block applies no reset value to the configuration word. The surrounding logic holds the configuration and should load it with 0x0020 after reset, which gives a threshold of 32 with toggle mode off.

Top module: `wm_irq_gen`

## Requirements
- R1: The watermark condition is true when the entry count is nonzero and is greater than or equal to the threshold. The status flag shows the condition one clock after the inputs are sampled.
- R2: A threshold field of 0 is treated as a threshold of 1.
- R3: Configuration bits 14:0 hold the threshold and bit 15 selects toggle mode (1 = toggle). Bit 15 does not take part in the threshold comparison.
- R4: In level mode, the interrupt pin equals the condition sampled on the previous clock, gated by hold.
- R5: In toggle mode, a run starts when the condition is met. The pin is high for TOGGLE_HALF clocks and then low for TOGGLE_HALF clocks, and this repeats. Every run begins with a high half.
- R6: A toggle run continues while the count is nonzero, even below the threshold. The pin is low from the clock after the count is sampled at zero.
- R7: After a run has ended, a count that meets the threshold again starts a new run with a full high half. A count that is nonzero but below the threshold does not start a run.
- R8: When hold is sampled high, the pin is low on the next clock and any toggle run is cancelled. After hold is released, a met condition starts a new run with a high half.
- R9: The status flag follows the condition whatever the values of hold and the mode bit.
- R10: After reset, the interrupt pin and the status flag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| entry_count | input | CNT_W | Number of entries currently stored in the buffer |
| cfg_word | input | 16 | Bit 15 selects toggle mode; bits 14:0 hold the threshold |
| hold_low | input | 1 | Forces the interrupt pin low and cancels any toggle run |
| irq_out | output | 1 | Watermark interrupt pin |
| wm_status | output | 1 | Registered watermark condition flag |

## Verification
The hardest state to reach is a toggle run that is still active after the count has dropped below the threshold without reaching zero. That is the only situation in which the run's memory is visible separately from the comparison. The stimulus fills the buffer to the threshold, then lowers the count to one entry and holds it there across several half periods. It then empties the buffer and refills it below the threshold to show that no new run starts. A hold pulse in the middle of a run is used to check both the cancellation and the fresh high half after release.

// File: rtl/wm_pkg.sv
package wm_pkg;
  localparam int unsigned CFG_W = 16;
  localparam int unsigned THR_W = CFG_W - 1;

  typedef struct packed {
    logic             toggle_en;
    logic [THR_W-1:0] level;
  } wm_cfg_t;
endpackage

// File: rtl/wm_cond.sv
module wm_cond
  import wm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic [CNT_W-1:0] count,
  input  logic [THR_W-1:0] level,
  output logic             nonempty,
  output logic             met
);
  localparam int unsigned CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

  logic [CMP_W-1:0] cnt_ext;
  logic [CMP_W-1:0] thr_ext;

  always_comb begin
    cnt_ext = CMP_W'(count);
    thr_ext = (level == '0) ? CMP_W'(1) : CMP_W'(level);
    nonempty = (count != '0);
    met = nonempty && (cnt_ext >= thr_ext);
  end
endmodule

// File: rtl/wm_toggle.sv
module wm_toggle #(
  parameter int unsigned HALF_CYC = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic start,
  output logic wave
);
  logic run_q;
  logic phase_q;

  generate
    if (HALF_CYC <= 1) begin : g_nodiv
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          run_q   <= 1'b0;
          phase_q <= 1'b0;
        end else if (clear) begin
          run_q   <= 1'b0;
          phase_q <= 1'b0;
        end else if (!run_q && start) begin
          run_q   <= 1'b1;
          phase_q <= 1'b1;
        end else if (run_q) begin
          phase_q <= ~phase_q;
        end
      end
    end else begin : g_div
      localparam int unsigned DIV_W = $clog2(HALF_CYC);
      localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_CYC - 1);
      logic [DIV_W-1:0] div_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          run_q   <= 1'b0;
          phase_q <= 1'b0;
          div_q   <= '0;
        end else if (clear) begin
          run_q   <= 1'b0;
          phase_q <= 1'b0;
          div_q   <= '0;
        end else if (!run_q && start) begin
          run_q   <= 1'b1;
          phase_q <= 1'b1;
          div_q   <= '0;
        end else if (run_q) begin
          if (div_q == DIV_LAST) begin
            div_q   <= '0;
            phase_q <= ~phase_q;
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
      end
    end
  endgenerate

  assign wave = run_q & phase_q;
endmodule

// File: rtl/wm_irq_gen.sv
module wm_irq_gen
  import wm_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned TOGGLE_HALF = 5000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] entry_count,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             hold_low,
  output logic             irq_out,
  output logic             wm_status
);
  wm_cfg_t cfg;
  logic    nonempty;
  logic    met;
  logic    tog_clear;
  logic    wave;
  logic    level_q;
  logic    mode_q;
  logic    status_q;

  assign cfg = wm_cfg_t'(cfg_word);

  wm_cond #(.CNT_W(CNT_W)) u_cond (
    .count    (entry_count),
    .level    (cfg.level),
    .nonempty (nonempty),
    .met      (met)
  );

  assign tog_clear = hold_low | ~cfg.toggle_en | ~nonempty;

  wm_toggle #(.HALF_CYC(TOGGLE_HALF)) u_toggle (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (tog_clear),
    .start (met),
    .wave  (wave)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q  <= 1'b0;
      mode_q   <= 1'b0;
      status_q <= 1'b0;
    end else begin
      level_q  <= met & ~hold_low;
      mode_q   <= cfg.toggle_en;
      status_q <= met;
    end
  end

  assign irq_out   = mode_q ? wave : level_q;
  assign wm_status = status_q;
endmodule

// File: rtl/wm_irq_chk.sv
module wm_irq_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] entry_count,
  input logic [15:0]      cfg_word,
  input logic             hold_low,
  input logic             irq_out,
  input logic             wm_status
);
  // R8
  hold_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_low |=> !irq_out);

  // R1
  empty_no_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_count == '0) |=> !wm_status);

  // R6
  empty_pin_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_count == '0) |=> !irq_out);

  // R4
  level_mode_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_word[15] && !hold_low) |=> (irq_out == wm_status));

  // R2
  thr_zero_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_word[14:0] == '0 && entry_count != '0) |=> wm_status);
endmodule

bind wm_irq_gen wm_irq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .entry_count (entry_count),
  .cfg_word    (cfg_word),
  .hold_low    (hold_low),
  .irq_out     (irq_out),
  .wm_status   (wm_status)
);

// File: tb/wm_irq_gen_tb.sv
module wm_irq_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int HALF = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] entry_count = '0;
  logic [15:0]      cfg_word = 16'h0020;
  logic             hold_low = 1'b0;
  logic             irq_out;
  logic             wm_status;

  int    n_checks = 0;
  int    n_fail = 0;
  bit    checking = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R10";

  // behavioural reference
  bit m_irq = 0, m_st = 0, m_run = 0;
  int m_el = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wm_irq_gen #(.CNT_W(CNT_W), .TOGGLE_HALF(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .entry_count(entry_count), .cfg_word(cfg_word),
    .hold_low(hold_low), .irq_out(irq_out), .wm_status(wm_status)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_irq = 0; m_st = 0; m_run = 0; m_el = 0;
    end else begin
      int  thr;
      bit  met;
      thr = (cfg_word[14:0] == 0) ? 1 : int'(cfg_word[14:0]);
      met = (entry_count != 0) && (int'(entry_count) >= thr);
      m_st = met;
      if (hold_low || !cfg_word[15] || entry_count == 0) begin
        m_run = 0; m_el = 0;
      end else if (!m_run && met) begin
        m_run = 1; m_el = 0;
      end else if (m_run) begin
        m_el++;
      end
      if (cfg_word[15]) m_irq = m_run && (((m_el / HALF) % 2) == 0);
      else              m_irq = met && !hold_low;
    end
  end

  task automatic check(string req, bit act, bit exp, string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (checking && !done) begin
      check(cur_req, irq_out, m_irq, "irq_out");
      check(cur_req, wm_status, m_st, "wm_status");
    end
  end

  task automatic drive(string req, int cnt, logic [15:0] cfg, bit hold, int cycles);
    @(negedge clk);
    cur_req = req;
    entry_count = CNT_W'(cnt);
    cfg_word = cfg;
    hold_low = hold;
    repeat (cycles - 1) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10", irq_out, 1'b0, "reset irq_out");
    check("R10", wm_status, 1'b0, "reset wm_status");
    rst_n = 1'b1;
    checking = 1'b1;

    // R1 / R4: level mode, threshold 32
    drive("R1", 0, 16'h0020, 0, 2);
    drive("R1", 5, 16'h0020, 0, 2);
    drive("R1", 31, 16'h0020, 0, 2);
    drive("R4", 32, 16'h0020, 0, 3);
    drive("R4", 40, 16'h0020, 0, 2);
    drive("R4", 10, 16'h0020, 0, 2);
    @(negedge clk);
    check("R4", irq_out, 1'b0, "below threshold level pin");
    // R2: threshold 0 acts as 1
    drive("R2", 0, 16'h0000, 0, 2);
    drive("R2", 1, 16'h0000, 0, 2);
    check("R2", wm_status, 1'b1, "count 1 with threshold 0");
    // R3: bit 15 not part of threshold
    drive("R3", 3, 16'h0003, 0, 2);
    drive("R3", 2, 16'h8003, 0, 3);
    check("R3", irq_out, 1'b0, "toggle mode below threshold");
    // R5: toggle run
    drive("R5", 0, 16'h8003, 0, 2);
    drive("R5", 3, 16'h8003, 0, 1);
    @(negedge clk);
    check("R5", irq_out, 1'b1, "first half high");
    drive("R5", 3, 16'h8003, 0, 20);
    // R6: keep running below threshold, stop at empty
    drive("R6", 1, 16'h8003, 0, 12);
    drive("R6", 0, 16'h8003, 0, 1);
    @(negedge clk);
    check("R6", irq_out, 1'b0, "pin low after empty");
    drive("R6", 0, 16'h8003, 0, 3);
    // R7: no restart below threshold, restart at threshold
    drive("R7", 2, 16'h8003, 0, 6);
    drive("R7", 4, 16'h8003, 0, 1);
    @(negedge clk);
    check("R7", irq_out, 1'b1, "restart high");
    drive("R7", 4, 16'h8003, 0, 10);
    // R8: hold mid-run, then release
    drive("R8", 4, 16'h8003, 1, 1);
    @(negedge clk);
    check("R8", irq_out, 1'b0, "held low");
    drive("R8", 4, 16'h8003, 1, 4);
    drive("R8", 4, 16'h8003, 0, 12);
    // R9: status ignores hold and mode
    drive("R9", 40, 16'h0020, 1, 1);
    @(negedge clk);
    check("R9", wm_status, 1'b1, "status under hold");
    check("R9", irq_out, 1'b0, "level pin under hold");
    drive("R9", 40, 16'h0020, 1, 3);
    drive("R9", 40, 16'h0020, 0, 3);
    drive("R9", 0, 16'h0020, 0, 3);
    checking = 1'b0;
    finish_run();
  end
endmodule